// File: doc/BRIEF.md
# Dual Interval Timer Prescaler

This block turns a slow, free-running external timer clock into count steps for two 16-bit interval timers. The raw timer clock has no fixed relation to the system clock. A chain of flops brings it into the system clock domain. A falling-edge detector then makes a single-cycle step pulse for each timer clock period. With a nominal 100 kHz timer clock, timer A advances every 10 microseconds. A free-running decade prescaler passes on every tenth pulse to timer B, which advances every 100 microseconds.

Each timer is an up counter with its own start, stop and load controls. When a timer wraps from all ones to zero, it sets a rollover flag. The flag stays set until that timer is loaded. The logic that decodes commands into these controls sits outside this block, and so does any interrupt raised from the flags.

Top module: `interval_timer_pair`

## Requirements
- R1: After reset, both counts read 0 and both rollover flags read 0. Both timers are stopped, so timer clock edges alone change neither count.
- R2: When the raw timer clock goes from 1 to 0, a running timer A changes count on the third rising system clock edge after the change. A 0 to 1 change of the raw timer clock steps neither timer.
- R3: While running, timer A adds exactly 1 for each falling edge of the raw timer clock.
- R4: While running, timer B adds 1 for every 10th falling edge of the raw timer clock. This step falls on the same system clock edge as the timer A step for that falling edge.
- R5: The divide-by-10 prescaler counts every falling edge from reset onward, whether either timer is running or stopped. Only reset clears it. Starting or stopping timer B therefore does not change the phase of its steps.
- R6: A stop pulse makes a timer hold its count. A later start pulse makes it count again from the held value.
- R7: A load pulse writes the 16-bit load value into its timer on the next clock edge and clears that timer's flag. Load takes priority over a step in the same cycle and does not change whether the timer runs.
- R8: A step from 16'hFFFF makes the count 16'h0000 and sets the rollover flag. The flag stays set through further counting until the next load of that timer.
- R9: When start and stop arrive in the same cycle, stop wins and the timer ends up stopped.
- R10: The controls of one timer do not change the count, flag or run state of the other timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (machine-cycle) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tclk_raw | input | 1 | Raw external timer clock, asynchronous |
| start_a | input | 1 | One-cycle pulse that sets timer A running |
| stop_a | input | 1 | One-cycle pulse that stops timer A |
| load_a | input | 1 | One-cycle pulse that loads timer A |
| load_val_a | input | 16 | Value written into timer A on load |
| start_b | input | 1 | One-cycle pulse that sets timer B running |
| stop_b | input | 1 | One-cycle pulse that stops timer B |
| load_b | input | 1 | One-cycle pulse that loads timer B |
| load_val_b | input | 16 | Value written into timer B on load |
| count_a | output | 16 | Timer A count |
| count_b | output | 16 | Timer B count |
| wrap_a | output | 1 | Sticky rollover flag of timer A |
| wrap_b | output | 1 | Sticky rollover flag of timer B |

## Verification
The bench builds the block with its default parameters: 16-bit counts, a prescale ratio of 10 and two synchronizer stages. It loads values just below 16'hFFFF so that both wrap events are reached within a few timer clock periods, where counting up from zero would take 65,536. Because the ratio is 10, a run of a few dozen timer clock periods already covers several prescaler turns. That length is enough to show the phase kept across stop and start of timer B, and the exact synchronizer latency is checked cycle by cycle.

// File: rtl/itp_pkg.sv
package itp_pkg;

  localparam int unsigned NUM_TIMERS = 2;
  localparam int unsigned TIMER_A    = 0;
  localparam int unsigned TIMER_B    = 1;

  // Next value of an up counter of any width up to 32 bits.
  function automatic logic [31:0] itp_incr(input logic [31:0] value, input int unsigned width);
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return (value + 32'd1) & mask;
  endfunction

  // True when the counter sits at its all-ones value.
  function automatic logic itp_at_top(input logic [31:0] value, input int unsigned width);
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return (value & mask) == mask;
  endfunction

  // Next state of a modulo-ratio divider.
  function automatic logic [31:0] itp_div_next(input logic [31:0] phase, input int unsigned ratio);
    return (phase == ratio - 1) ? 32'd0 : phase + 32'd1;
  endfunction

endpackage

// File: rtl/itp_edge_sync.sv
module itp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign synced = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= synced;
  end

  assign fall_o = last_q & ~synced;

  // R2: a falling edge yields a single-cycle pulse
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/itp_decade_div.sv
module itp_decade_div
  import itp_pkg::*;
#(
  parameter int unsigned RATIO = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic tick_o
);

  localparam int unsigned PW = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [PW-1:0] phase_q;
  logic          last_phase;

  assign last_phase = (32'(phase_q) == RATIO - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (tick_i) phase_q <= PW'(itp_div_next(32'(phase_q), RATIO));
  end

  assign tick_o = tick_i & last_phase;

  // R5: phase never leaves its range
  assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phase_q) < RATIO);

  // R5: phase advances only on an input tick
  assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(phase_q));

endmodule

// File: rtl/itp_interval_counter.sv
module itp_interval_counter
  import itp_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic             wrap_o
);

  logic             running_q;
  logic [WIDTH-1:0] count_q;
  logic             wrap_q;
  logic             advance;
  logic             rolls;

  assign advance = running_q & step_i & ~load_i;
  assign rolls   = advance & itp_at_top(32'(count_q), WIDTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       running_q <= 1'b0;
    else if (stop_i)  running_q <= 1'b0;
    else if (start_i) running_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (load_i)  count_q <= load_val_i;
    else if (advance) count_q <= WIDTH'(itp_incr(32'(count_q), WIDTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wrap_q <= 1'b0;
    else if (load_i) wrap_q <= 1'b0;
    else if (rolls)  wrap_q <= 1'b1;
  end

  assign count_o = count_q;
  assign wrap_o  = wrap_q;

  assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && step_i && !load_i) |=> (count_q == WIDTH'($past(count_q) + 1'b1)));

  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !load_i) |=> $stable(count_q));

  assert_load_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_q == $past(load_val_i)) && !wrap_q);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && !load_i) |=> wrap_q);

  assert_stop_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !running_q);

endmodule

// File: rtl/interval_timer_pair.sv
module interval_timer_pair
  import itp_pkg::*;
#(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned RATIO       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tclk_raw,
  input  logic             start_a,
  input  logic             stop_a,
  input  logic             load_a,
  input  logic [WIDTH-1:0] load_val_a,
  input  logic             start_b,
  input  logic             stop_b,
  input  logic             load_b,
  input  logic [WIDTH-1:0] load_val_b,
  output logic [WIDTH-1:0] count_a,
  output logic [WIDTH-1:0] count_b,
  output logic             wrap_a,
  output logic             wrap_b
);

  logic                  step_fast;
  logic                  step_slow;
  logic [NUM_TIMERS-1:0] step_v;
  logic [NUM_TIMERS-1:0] start_v;
  logic [NUM_TIMERS-1:0] stop_v;
  logic [NUM_TIMERS-1:0] load_v;
  logic [WIDTH-1:0]      load_val_v [NUM_TIMERS];
  logic [WIDTH-1:0]      count_v    [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] wrap_v;

  itp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(tclk_raw),
    .fall_o (step_fast)
  );

  itp_decade_div #(.RATIO(RATIO)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_i(step_fast),
    .tick_o(step_slow)
  );

  assign step_v[TIMER_A]     = step_fast;
  assign step_v[TIMER_B]     = step_slow;
  assign start_v             = {start_b, start_a};
  assign stop_v              = {stop_b, stop_a};
  assign load_v              = {load_b, load_a};
  assign load_val_v[TIMER_A] = load_val_a;
  assign load_val_v[TIMER_B] = load_val_b;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
    itp_interval_counter #(.WIDTH(WIDTH)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (step_v[t]),
      .start_i   (start_v[t]),
      .stop_i    (stop_v[t]),
      .load_i    (load_v[t]),
      .load_val_i(load_val_v[t]),
      .count_o   (count_v[t]),
      .wrap_o    (wrap_v[t])
    );
  end

  assign count_a = count_v[TIMER_A];
  assign count_b = count_v[TIMER_B];
  assign wrap_a  = wrap_v[TIMER_A];
  assign wrap_b  = wrap_v[TIMER_B];

  // R4: every slow step coincides with a fast step
  assert_slow_with_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_slow |-> step_fast);

  // R10: an idle timer B is untouched by timer A controls
  assert_b_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_slow && !load_b) |=> $stable(count_b));

endmodule

// File: tb/interval_timer_pair_tb.sv
module interval_timer_pair_tb_top;

  localparam int unsigned W = 16;
  localparam int unsigned RATIO = 10;
  localparam int unsigned NV = 16;

  // ops: 0 none, 1 start A, 2 stop A, 3 start B, 4 stop B, 5 load A, 6 load B
  // entry layout: {op[3:0], value[15:0], periods[7:0], req[3:0]}
  localparam logic [31:0] VEC [NV] = '{
    {4'd1, 16'h0000, 8'd3,  4'd3},   // R3 start A, count edges
    {4'd0, 16'h0000, 8'd7,  4'd5},   // R5 prescaler turns with B stopped
    {4'd3, 16'h0000, 8'd10, 4'd4},   // R4 B steps every tenth edge
    {4'd2, 16'h0000, 8'd5,  4'd6},   // R6 A holds while stopped
    {4'd1, 16'h0000, 8'd5,  4'd6},   // R6 A resumes
    {4'd5, 16'hFFFD, 8'd2,  4'd7},   // R7 load A near top
    {4'd0, 16'h0000, 8'd1,  4'd8},   // R8 A wraps, flag set
    {4'd0, 16'h0000, 8'd4,  4'd8},   // R8 flag sticky
    {4'd6, 16'hFFFF, 8'd9,  4'd7},   // R7 load B at top
    {4'd0, 16'h0000, 8'd10, 4'd8},   // R8 B wraps
    {4'd5, 16'h1234, 8'd0,  4'd7},   // R7 load clears A flag
    {4'd4, 16'h0000, 8'd7,  4'd6},   // R6 stop B, prescaler runs on
    {4'd6, 16'h00AA, 8'd3,  4'd7},   // R7 load keeps B stopped
    {4'd3, 16'h0000, 8'd13, 4'd5},   // R5 B phase kept across stop
    {4'd2, 16'h0000, 8'd2,  4'd10},  // R10 A stop leaves B running
    {4'd5, 16'h0007, 8'd2,  4'd10}   // R10 A load leaves B alone
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tclk_raw = 1'b0;
  logic          start_a = 1'b0, stop_a = 1'b0, load_a = 1'b0;
  logic          start_b = 1'b0, stop_b = 1'b0, load_b = 1'b0;
  logic [W-1:0]  load_val_a = '0, load_val_b = '0;
  logic [W-1:0]  count_a, count_b;
  logic          wrap_a, wrap_b;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] ea = '0, eb = '0;
  logic         fa = 1'b0, fb = 1'b0, ra = 1'b0, rb = 1'b0;
  int           pre = 0;

  always #4 clk = ~clk;

  interval_timer_pair #(.WIDTH(W), .RATIO(RATIO), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .tclk_raw(tclk_raw),
    .start_a(start_a), .stop_a(stop_a), .load_a(load_a), .load_val_a(load_val_a),
    .start_b(start_b), .stop_b(stop_b), .load_b(load_b), .load_val_b(load_val_b),
    .count_a(count_a), .count_b(count_b), .wrap_a(wrap_a), .wrap_b(wrap_b)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one full raw timer clock period; the model follows each falling edge
  task automatic raw_period();
    tclk_raw = 1'b1;
    cyc(4);
    tclk_raw = 1'b0;
    cyc(4);
    if (ra) begin
      if (ea == 16'hFFFF) fa = 1'b1;
      ea = ea + 16'd1;
    end
    pre = pre + 1;
    if (pre == RATIO) begin
      pre = 0;
      if (rb) begin
        if (eb == 16'hFFFF) fb = 1'b1;
        eb = eb + 16'd1;
      end
    end
  endtask

  task automatic apply_op(input logic [3:0] op, input logic [15:0] val);
    case (op)
      4'd1: begin start_a = 1'b1; ra = 1'b1; end
      4'd2: begin stop_a  = 1'b1; ra = 1'b0; end
      4'd3: begin start_b = 1'b1; rb = 1'b1; end
      4'd4: begin stop_b  = 1'b1; rb = 1'b0; end
      4'd5: begin load_a = 1'b1; load_val_a = val; ea = val; fa = 1'b0; end
      4'd6: begin load_b = 1'b1; load_val_b = val; eb = val; fb = 1'b0; end
      default: ;
    endcase
    cyc(1);
    {start_a, stop_a, load_a, start_b, stop_b, load_b} = '0;
  endtask

  task automatic check_all(input string req);
    check(req, "count_a", 32'(count_a), 32'(ea));
    check(req, "count_b", 32'(count_b), 32'(eb));
    check(req, "wrap_a",  32'(wrap_a),  32'(fa));
    check(req, "wrap_b",  32'(wrap_b),  32'(fb));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1: reset state
    check_all("R1");
    // R1: stopped timers ignore edges
    raw_period();
    raw_period();
    check_all("R1");

    // R2: exact latency from a raw falling edge
    apply_op(4'd1, '0);
    tclk_raw = 1'b1;
    cyc(4);
    check("R2", "rise does not step", 32'(count_a), 32'(ea));
    tclk_raw = 1'b0;
    cyc(2);
    check("R2", "no step after two edges", 32'(count_a), 32'(ea));
    cyc(1);
    check("R2", "step on third edge", 32'(count_a), 32'(ea + 16'd1));
    ea = ea + 16'd1;
    pre = pre + 1;
    cyc(2);
    apply_op(4'd2, '0);
    check_all("R6");

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op, rq;
      logic [15:0] val;
      logic [7:0] np;
      {op, val, np, rq} = VEC[i];
      apply_op(op, val);
      for (int k = 0; k < int'(np); k++) raw_period();
      check_all($sformatf("R%0d (vector %0d)", rq, i));
    end

    // R9: start and stop together leave the timer stopped
    start_a = 1'b1;
    stop_a  = 1'b1;
    ra = 1'b0;
    cyc(1);
    start_a = 1'b0;
    stop_a  = 1'b0;
    raw_period();
    raw_period();
    check("R9", "count_a held", 32'(count_a), 32'(ea));

    // R7: load wins over a step in the same cycle
    apply_op(4'd1, '0);
    tclk_raw = 1'b1;
    cyc(4);
    tclk_raw = 1'b0;
    cyc(2);
    load_a = 1'b1;
    load_val_a = 16'h5A5A;
    cyc(1);
    load_a = 1'b0;
    check("R7", "load beats step", 32'(count_a), 32'h5A5A);
    check("R7", "flag clear after load", 32'(wrap_a), 32'd0);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    cyc(1);
    rst_n = 1'b1;
    ea = '0; eb = '0; fa = 1'b0; fb = 1'b0; ra = 1'b0; rb = 1'b0; pre = 0;
    tclk_raw = 1'b0;
    cyc(2);
    check_all("R1");

    summary();
    $finish;
  end

endmodule